// File: doc/BRIEF.md
# Three-Smallest Reliability Selector

This block scans a soft-decision codeword of 32 unsigned reliability magnitudes and reports the three least reliable positions: the three smallest magnitudes in ascending order, each with its 5-bit position. A Chase-style soft decoder uses these positions to build its test patterns. The block produces a partial ordering only. It does not sort the full vector, handle signs, generate patterns or keep any storage beyond optional pipeline registers.

Each magnitude is paired with its own position to form a comparison key, with the magnitude in the upper bits. The network then applies a series of halving shuffle stages. Each stage runs compare-and-select cells between the lower and upper halves of the surviving set. The lower halves keep the running minimum. A minimum tree reduces each discarded upper half to one candidate, because such a half can hold at most one of the second or third minima. After five stages one key is left, and that key is the smallest. A final pick-two over the five candidates gives the second and third minima.

A bit mask parameter chooses which stage boundaries get a register. The five shuffle stages and the final pick can each be registered. With an empty mask the block is purely combinational. The valid flag moves through exactly the same registers as the data.

Top module: `lr_min3_finder`

## Requirements
- R1: Output slot 0 holds the smallest of the 32 input magnitudes together with its position.
- R2: Output slots 1 and 2 hold the second and third smallest inputs, so the slot magnitudes never decrease from slot 0 to slot 2.
- R3: Among equal magnitudes the lower position ranks first, and the three reported positions are always distinct.
- R4: `out_valid` equals `in_valid` delayed by as many cycles as `PIPE_MASK` has set bits among its low six bits. Each accepted vector produces exactly one result, in order, and back-to-back vectors are accepted.
- R5: While `rst_n` is low, `out_valid` is 0. In the default build, where the final pick is registered, `out_mags` and `out_idxs` are also 0 during reset.
- R6: Input element i sits at `in_mags[i*5 +: 5]` and has position i. Output slot k has its magnitude at `out_mags[k*5 +: 5]` and its position at `out_idxs[k*5 +: 5]`.
- R7: When all 32 magnitudes are equal, the reported positions are 0, 1 and 2 in slots 0, 1 and 2, and all three magnitudes equal the common value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional pipeline registers |
| rst_n | input | 1 | Active-low synchronous reset of the pipeline registers |
| in_valid | input | 1 | Marks `in_mags` as a vector to be processed |
| in_mags | input | 160 | 32 reliability magnitudes, 5 bits each, element i at bits i*5 |
| out_valid | output | 1 | Marks the result slots as valid |
| out_mags | output | 15 | Three smallest magnitudes, slot 0 lowest |
| out_idxs | output | 15 | Positions of the three reported magnitudes |

## Verification
Two events can occur in the same cycle. The first is the tie-break, where equal magnitudes are ordered by position. The second is the split of the two runner-up minima between a discarded upper half and the surviving lower half. The bench provokes both at once with all-equal vectors, with vectors whose small values share a magnitude across the two halves of a stage, and with random vectors drawn from a four-value range. Each result is judged against a bench reference that selects the three smallest magnitudes by repeated lowest-position search. The second event also coincides with pipeline overlap: a new vector is accepted in the same cycle as an older result leaves. Streaming vectors back to back with random idle gaps covers this, and every result is matched in order against the queued reference values.

// File: rtl/lr_pkg.sv
package lr_pkg;

  // Number of set bits among the lowest nbits of a stage mask.
  function automatic int popcount_low(input logic [31:0] mask, input int nbits);
    int c;
    c = 0;
    for (int b = 0; b < nbits; b++) begin
      if (mask[b]) c++;
    end
    return c;
  endfunction

  // Number of surviving keys after shuffle stage s of an n-key network.
  function automatic int survivors_after(input int n, input int s);
    return n >> (s + 1);
  endfunction

endpackage

// File: rtl/lr_cas.sv
// Compare-and-select cell: routes the smaller key low, the larger key high.
module lr_cas #(
  parameter int KW = 10
) (
  input  logic [KW-1:0] a_i,
  input  logic [KW-1:0] b_i,
  output logic [KW-1:0] lo_o,
  output logic [KW-1:0] hi_o
);
  logic swap;
  assign swap = b_i < a_i;
  assign lo_o = swap ? b_i : a_i;
  assign hi_o = swap ? a_i : b_i;
endmodule

// File: rtl/lr_min_tree.sv
// Balanced minimum tree over M keys (M a power of two).
module lr_min_tree #(
  parameter int KW = 10,
  parameter int M  = 16
) (
  input  logic [M*KW-1:0] keys_i,
  output logic [KW-1:0]   min_o
);
  localparam int D = (M > 1) ? $clog2(M) : 0;

  function automatic logic [KW-1:0] lesser(input logic [KW-1:0] a, input logic [KW-1:0] b);
    return (b < a) ? b : a;
  endfunction

  for (genvar lv = 0; lv <= D; lv++) begin : g_lv
    localparam int CNT = M >> lv;
    logic [CNT*KW-1:0] v;
    if (lv == 0) begin : g_leaf
      assign v = keys_i;
    end else begin : g_node
      for (genvar j = 0; j < CNT; j++) begin : g_pair
        assign v[j*KW +: KW] = lesser(g_lv[lv-1].v[(2*j)*KW +: KW],
                                      g_lv[lv-1].v[(2*j+1)*KW +: KW]);
      end
    end
  end

  assign min_o = g_lv[D].v;
endmodule

// File: rtl/lr_shuffle_stage.sv
// One halving stage: pairs key j with key j+HALF, keeps the lower of each
// pair, and reduces the discarded upper half to a single candidate.
module lr_shuffle_stage #(
  parameter int KW   = 10,
  parameter int HALF = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v_i,
  input  logic [2*HALF*KW-1:0] low_i,
  output logic [HALF*KW-1:0]   low_o,
  output logic [KW-1:0]        cand_o
);
  logic [HALF*KW-1:0] up;

  for (genvar j = 0; j < HALF; j++) begin : g_cas
    lr_cas #(.KW(KW)) u_cas (
      .a_i  (low_i[j*KW +: KW]),
      .b_i  (low_i[(j+HALF)*KW +: KW]),
      .lo_o (low_o[j*KW +: KW]),
      .hi_o (up[j*KW +: KW])
    );
  end

  lr_min_tree #(.KW(KW), .M(HALF)) u_up_min (
    .keys_i (up),
    .min_o  (cand_o)
  );

  // Check logic: floor of the kept half, computed independently of the tree.
  logic [KW-1:0] low_floor;
  always_comb begin
    low_floor = '1;
    for (int j = 0; j < HALF; j++) begin
      if (low_o[j*KW +: KW] < low_floor) low_floor = low_o[j*KW +: KW];
    end
  end

  // R1: the discarded half's candidate never beats the kept half.
  p_cand_above_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    v_i |-> (cand_o > low_floor));
endmodule

// File: rtl/lr_pick2.sv
// Smallest two keys of M candidates by a running insertion.
module lr_pick2 #(
  parameter int KW = 10,
  parameter int M  = 5
) (
  input  logic [M*KW-1:0] keys_i,
  output logic [KW-1:0]   first_o,
  output logic [KW-1:0]   second_o
);
  logic [KW-1:0] f, s, c;

  always_comb begin
    f = '1;
    s = '1;
    c = '0;
    for (int j = 0; j < M; j++) begin
      c = keys_i[j*KW +: KW];
      if (c < f) begin
        s = f;
        f = c;
      end else if (c < s) begin
        s = c;
      end
    end
  end

  assign first_o  = f;
  assign second_o = s;
endmodule

// File: rtl/lr_min3_finder.sv
module lr_min3_finder #(
  parameter int          N         = 32,
  parameter int          W         = 5,
  parameter logic [31:0] PIPE_MASK = 32'h0000_0024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [N*W-1:0]   in_mags,
  output logic             out_valid,
  output logic [3*W-1:0]   out_mags,
  output logic [3*$clog2(N)-1:0] out_idxs
);
  localparam int IW  = $clog2(N);
  localparam int S   = IW;
  localparam int KW  = W + IW;
  localparam int LAT = lr_pkg::popcount_low(PIPE_MASK, S + 1);

  // Key = {magnitude, position}: lower position wins on equal magnitude.
  logic [N*KW-1:0] keys;
  for (genvar i = 0; i < N; i++) begin : g_key
    assign keys[i*KW +: KW] = {in_mags[i*W +: W], IW'(i)};
  end

  for (genvar s = 0; s < S; s++) begin : g_st
    localparam int HALF = lr_pkg::survivors_after(N, s);
    logic [2*HALF*KW-1:0] low_in;
    logic                 v_in;
    logic [HALF*KW-1:0]   low_c, low_q;
    logic [KW-1:0]        cand_new;
    logic [(s+1)*KW-1:0]  acc_c, acc_q;
    logic                 v_q;

    if (s == 0) begin : g_first
      assign low_in = keys;
      assign v_in   = in_valid;
      assign acc_c  = cand_new;
    end else begin : g_next
      assign low_in = g_st[s-1].low_q;
      assign v_in   = g_st[s-1].v_q;
      assign acc_c  = {cand_new, g_st[s-1].acc_q};
    end

    lr_shuffle_stage #(.KW(KW), .HALF(HALF)) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .v_i    (v_in),
      .low_i  (low_in),
      .low_o  (low_c),
      .cand_o (cand_new)
    );

    if (PIPE_MASK[s]) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          low_q <= '0;
          acc_q <= '0;
          v_q   <= 1'b0;
        end else begin
          low_q <= low_c;
          acc_q <= acc_c;
          v_q   <= v_in;
        end
      end
    end else begin : g_wire
      assign low_q = low_c;
      assign acc_q = acc_c;
      assign v_q   = v_in;
    end
  end

  // Final pick: overall minimum plus best two of the five candidates.
  logic [KW-1:0]   m1_c, m2_c, m3_c;
  logic [S*KW-1:0] cands;
  logic            v_last;
  assign m1_c   = g_st[S-1].low_q;
  assign cands  = g_st[S-1].acc_q;
  assign v_last = g_st[S-1].v_q;

  lr_pick2 #(.KW(KW), .M(S)) u_pick (
    .keys_i   (cands),
    .first_o  (m2_c),
    .second_o (m3_c)
  );

  logic [3*KW-1:0] fin_c, fin_q;
  logic            fin_v;
  assign fin_c = {m3_c, m2_c, m1_c};

  if (PIPE_MASK[S]) begin : g_fin_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        fin_q <= '0;
        fin_v <= 1'b0;
      end else begin
        fin_q <= fin_c;
        fin_v <= v_last;
      end
    end
  end else begin : g_fin_wire
    assign fin_q = fin_c;
    assign fin_v = v_last;
  end

  assign out_valid = fin_v;
  for (genvar k = 0; k < 3; k++) begin : g_out
    assign out_mags[k*W +: W]   = fin_q[k*KW + IW +: W];
    assign out_idxs[k*IW +: IW] = fin_q[k*KW +: IW];
  end

  // ---------------- assertions ----------------
  function automatic logic all_above(input logic [KW-1:0] m, input logic [S*KW-1:0] c);
    for (int j = 0; j < S; j++) begin
      if (!(c[j*KW +: KW] > m)) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic [KW-1:0] slot_key(input int k, input logic [3*W-1:0] m,
                                             input logic [3*IW-1:0] ix);
    return {m[k*W +: W], ix[k*IW +: IW]};
  endfunction

  // R1: the survivor of the halving chain is below every candidate.
  p_min1_below_cands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    v_last |-> all_above(m1_c, cands));

  // R2: slots strictly ascend by (magnitude, position).
  p_sorted_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((slot_key(0, out_mags, out_idxs) < slot_key(1, out_mags, out_idxs)) &&
                   (slot_key(1, out_mags, out_idxs) < slot_key(2, out_mags, out_idxs))));

  // R3: reported positions are distinct.
  p_distinct_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_idxs[0 +: IW] != out_idxs[IW +: IW]) &&
                   (out_idxs[0 +: IW] != out_idxs[2*IW +: IW]) &&
                   (out_idxs[IW +: IW] != out_idxs[2*IW +: IW])));

  // R4: valid follows in_valid by the configured latency.
  logic [3:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 4'hF) since_rst <= since_rst + 4'd1;
  end

  if (LAT > 0) begin : g_lat_chk
    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 4'(LAT)) |-> (out_valid == $past(in_valid, LAT)));
  end else begin : g_comb_chk
    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == in_valid);
  end
endmodule

// File: tb/lr_min3_finder_bench.sv
`timescale 1ns/1ps
module lr_min3_finder_bench;
  localparam int N   = 32;
  localparam int W   = 5;
  localparam int IW  = 5;
  localparam int LAT = 2;   // default mask sets two boundaries
  localparam int QD  = 4096;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [N*W-1:0]   in_mags = '0;
  logic             out_valid;
  logic [3*W-1:0]   out_mags;
  logic [3*IW-1:0]  out_idxs;

  always #2.5 clk = ~clk;

  lr_min3_finder u_lr_min3_finder (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_mags   (in_mags),
    .out_valid (out_valid),
    .out_mags  (out_mags),
    .out_idxs  (out_idxs)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    finished = 1'b0;
  logic [3*W-1:0]  e_mag [QD];
  logic [3*IW-1:0] e_idx [QD];
  string           e_tag [QD];
  int    wr = 0;
  int    rd = 0;
  logic [7:0] vh = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference: three times pick the smallest untaken magnitude, first position wins.
  function automatic void ref_min3(input logic [N*W-1:0] v,
                                   output logic [3*W-1:0] m, output logic [3*IW-1:0] ix);
    bit taken [N];
    for (int i = 0; i < N; i++) taken[i] = 1'b0;
    m = '0; ix = '0;
    for (int k = 0; k < 3; k++) begin
      int best;
      best = -1;
      for (int i = 0; i < N; i++) begin
        if (!taken[i] && (best < 0 || v[i*W +: W] < v[best*W +: W])) best = i;
      end
      taken[best] = 1'b1;
      m[k*W +: W]   = v[best*W +: W];
      ix[k*IW +: IW] = IW'(best);
    end
  endfunction

  task automatic observe();
    check(out_valid == vh[LAT-1], "R4", "out_valid timing", 32'(out_valid), 32'(vh[LAT-1]));
    if (out_valid && rd < wr) begin
      check(out_mags[0 +: W] == e_mag[rd][0 +: W] && out_idxs[0 +: IW] == e_idx[rd][0 +: IW],
            "R1", {"slot0 ", e_tag[rd]},
            32'({out_mags[0 +: W], out_idxs[0 +: IW]}),
            32'({e_mag[rd][0 +: W], e_idx[rd][0 +: IW]}));
      check(out_mags[W +: 2*W] == e_mag[rd][W +: 2*W] && out_idxs[IW +: 2*IW] == e_idx[rd][IW +: 2*IW],
            "R2", {"slots1-2 ", e_tag[rd]},
            32'({out_mags[W +: 2*W], out_idxs[IW +: 2*IW]}),
            32'({e_mag[rd][W +: 2*W], e_idx[rd][IW +: 2*IW]}));
      rd++;
    end
  endtask

  task automatic step(input bit v, input logic [N*W-1:0] vec, input string tag);
    @(negedge clk);
    observe();
    in_valid = v;
    in_mags  = vec;
    vh = {vh[6:0], v};
    if (v && wr < QD) begin
      ref_min3(vec, e_mag[wr], e_idx[wr]);
      e_tag[wr] = tag;
      wr++;
    end
  endtask

  function automatic logic [N*W-1:0] fill(input logic [W-1:0] m);
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++) r[i*W +: W] = m;
    return r;
  endfunction

  function automatic logic [N*W-1:0] rnd_vec(input int mode);
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++) begin
      case (mode)
        0: r[i*W +: W] = W'($urandom_range(0, 31));
        1: r[i*W +: W] = W'($urandom_range(0, 3));
        default: r[i*W +: W] = ($urandom_range(0, 7) == 0) ? W'($urandom_range(0, 2)) : 5'd31;
      endcase
    end
    return r;
  endfunction

  task automatic finish_run();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    logic [N*W-1:0] v;
    void'($urandom(32'd20240611));
    // R5: reset state
    repeat (3) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R5", "out_valid in reset", 32'(out_valid), 0);
      check(out_mags == '0, "R5", "out_mags in reset", 32'(out_mags), 0);
      check(out_idxs == '0, "R5", "out_idxs in reset", 32'(out_idxs), 0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R7: all equal, maximum and zero
    step(1'b1, fill(5'd31), "R7 all-31");
    step(1'b1, fill(5'd0),  "R7 all-0");
    // R6: descending values put minima at the top positions
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(31 - i);
    step(1'b1, v, "R6 descending");
    v = fill(5'd20); v[31*W +: W] = 5'd0;
    step(1'b1, v, "R6 min at position 31");
    // Runner-up minima in one upper half, and in separate halves
    v = fill(5'd25); v[16*W +: W] = 5'd2; v[17*W +: W] = 5'd3; v[0*W +: W] = 5'd1;
    step(1'b1, v, "R2 both runners upper");
    v = fill(5'd25); v[3*W +: W] = 5'd4; v[19*W +: W] = 5'd4; v[11*W +: W] = 5'd4; v[27*W +: W] = 5'd4;
    step(1'b1, v, "R3 four-way tie across halves");
    v = fill(5'd9); v[30*W +: W] = 5'd1; v[14*W +: W] = 5'd1;
    step(1'b1, v, "R3 tie pair plus fill tie");
    // Idle gap
    step(1'b0, fill(5'd0), "idle");
    step(1'b0, fill(5'd3), "idle");

    for (int t = 0; t < 3000; t++) begin
      bit vv;
      int md;
      vv = ($urandom_range(0, 3) != 0);
      md = $urandom_range(0, 2);
      step(vv, rnd_vec(md), (md == 1) ? "R3 random ties" : "random");
    end
    for (int t = 0; t < LAT + 3; t++) step(1'b0, fill(5'd7), "drain");
    check(rd == wr, "R4", "result count", 32'(rd), 32'(wr));
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule